// File: doc/BRIEF.md
# Four-Channel Double-Buffered Converter Latch Bank

This block keeps the settings of four converter channels. Each channel owns two registers of the same shape: a staging register that takes decoded writes from an upstream serial receiver, and a live register whose contents drive the channel's outputs. A channel word is a 10-bit code, a power-down bit and a speed bit. The live registers follow the staging registers only while an active-low load input is held low. Software can therefore stage new values on several channels with load high and then release all of them in one cycle by pulling load low. With load tied low, every write reaches its channel one cycle later.

An active-low global power-down input forces every channel's enable output low, whatever its own power-down bit says. The stored codes and bits are untouched, so releasing the global power-down brings every channel back to the state it had before. Both asynchronous control inputs pass through a synchroniser of `SYNC_STAGES` flops. The load input acts on its level, not on its edges.

Top module: `chan_latch_bank`

## Requirements
- R1: While reset is asserted, and immediately after it is released, every staging and live register is zero. All codes and speed outputs read 0, and every enable reads 1 because no power-down bit is set.
- R2: A write with `wr_addr` equal to channel k changes only the staging register of channel k. A write whose address is `NUM_CH` or higher changes nothing.
- R3: While the synchronised load is active, a write to channel k appears on that channel's outputs at the first clock edge after the write cycle.
- R4: While the synchronised load is inactive, no live register changes. When load becomes active, all live registers copy their staging registers on the same edge.
- R5: While the synchronised global power-down is active, every bit of `ch_en` is 0.
- R6: When global power-down is released, each channel shows the code, enable and speed it had before, together with any writes made in the meantime.
- R7: When global power-down is inactive, `ch_en[k]` is the inverse of the channel's power-down bit (`wr_pdn` = 1 means powered down). `ch_fast[k]` equals the stored speed bit (1 = fast, 0 = slow). `ch_code[k*10 +: 10]` is the stored code.
- R8: `load_n` and `gpd_n` act through `SYNC_STAGES` synchronising flops. A level change on either input at the pin is seen by the register logic at the (`SYNC_STAGES`+1)-th rising edge. Holding `load_n` low keeps every live register tracking its staging register on every cycle.
- R9: If a write reaches channel k on the same edge as a load-driven transfer, channel k's live register takes the new write value, not the old staged value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Decoded write strobe, one cycle per word |
| wr_addr | input | ADDR_W (2) | Target channel of the write |
| wr_code | input | 10 | Converter code of the write |
| wr_pdn | input | 1 | Channel power-down bit of the write (1 = off) |
| wr_fast | input | 1 | Speed bit of the write (1 = fast) |
| load_n | input | 1 | Active-low, level-sensitive transfer control, asynchronous |
| gpd_n | input | 1 | Active-low global power-down, asynchronous |
| ch_code | output | NUM_CH*10 (40) | Live codes, channel k at bits k*10 +: 10 |
| ch_en | output | NUM_CH (4) | Effective channel enables |
| ch_fast | output | NUM_CH (4) | Live speed bits |

## Verification
Writes are tried with load held low, to show pass-through to the addressed channel only. They are repeated with load held high, which separates the staging register from the live register. A burst of writes to one channel runs across the cycle in which a delayed load release takes effect. This shows whether the write or the staged value wins the transfer edge and whether all channels switch on the same edge. Global power-down is asserted with mixed per-channel power-down bits and writes in flight. This separates an override that masks the enables from one that loses the stored state. A long stretch of random writes, load toggles and power-down toggles is then compared on every cycle against a behavioural model that applies the same synchroniser delay.

// File: rtl/clb_pkg.sv
package clb_pkg;

   localparam int unsigned CODE_W = 10;

   typedef struct packed {
      logic              pdn;
      logic              fast;
      logic [CODE_W-1:0] code;
   } chan_word_t;

   localparam int unsigned WORD_W = $bits(chan_word_t);

endpackage

// File: rtl/clb_sync.sv
module clb_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] pipe;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pipe <= {STAGES{RST_VAL}};
            end else begin
               pipe[0] <= d;
               for (int i = 1; i < STAGES; i++) begin
                  pipe[i] <= pipe[i-1];
               end
            end
         end
         assign q = pipe[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/clb_dec.sv
module clb_dec #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned ADDR_W = 2
) (
   input  logic              valid,
   input  logic [ADDR_W-1:0] addr,
   output logic [NUM_CH-1:0] hit
);

   generate
      for (genvar k = 0; k < NUM_CH; k++) begin : g_hit
         assign hit[k] = valid && (addr == ADDR_W'(k));
      end
   endgenerate

endmodule

// File: rtl/clb_chan.sv
module clb_chan
   import clb_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_hit,
   input  chan_word_t wr_word,
   input  logic       xfer,
   output chan_word_t live
);

   chan_word_t staged;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         staged <= '0;
      end else if (wr_hit) begin
         staged <= wr_word;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live <= '0;
      end else if (xfer) begin
         live <= wr_hit ? wr_word : staged;
      end
   end

endmodule

// File: rtl/chan_latch_bank.sv
module chan_latch_bank
   import clb_pkg::*;
#(
   parameter int unsigned NUM_CH      = 4,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned ADDR_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_valid,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [CODE_W-1:0]        wr_code,
   input  logic                     wr_pdn,
   input  logic                     wr_fast,
   input  logic                     load_n,
   input  logic                     gpd_n,
   output logic [NUM_CH*CODE_W-1:0] ch_code,
   output logic [NUM_CH-1:0]        ch_en,
   output logic [NUM_CH-1:0]        ch_fast
);

   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("chan_latch_bank: NUM_CH must be at least 1");
      end
      if (SYNC_STAGES > 8) begin : g_bad_sync
         $error("chan_latch_bank: SYNC_STAGES above 8 is not supported");
      end
   endgenerate

   logic              load_n_s;
   logic              gpd_n_s;
   logic              load_act;
   logic              gpd_act;
   logic [NUM_CH-1:0] hit;
   logic [NUM_CH-1:0] work_pdn;
   chan_word_t        wr_word;

   clb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_load (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (load_n),
      .q     (load_n_s)
   );

   clb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_gpd (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (gpd_n),
      .q     (gpd_n_s)
   );

   assign load_act = ~load_n_s;
   assign gpd_act  = ~gpd_n_s;

   clb_dec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
      .valid (wr_valid),
      .addr  (wr_addr),
      .hit   (hit)
   );

   always_comb begin
      wr_word.pdn  = wr_pdn;
      wr_word.fast = wr_fast;
      wr_word.code = wr_code;
   end

   generate
      for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
         chan_word_t live;

         clb_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hit  (hit[k]),
            .wr_word (wr_word),
            .xfer    (load_act),
            .live    (live)
         );

         assign ch_code[k*CODE_W +: CODE_W] = live.code;
         assign ch_fast[k]                  = live.fast;
         assign work_pdn[k]                 = live.pdn;
         assign ch_en[k]                    = ~live.pdn & ~gpd_act;
      end
   endgenerate

endmodule

// File: rtl/clb_checker.sv
module clb_checker
   import clb_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned ADDR_W = 2
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     wr_valid,
   input logic [ADDR_W-1:0]        wr_addr,
   input logic [CODE_W-1:0]        wr_code,
   input logic                     load_act,
   input logic                     gpd_act,
   input logic [NUM_CH-1:0]        work_pdn,
   input logic [NUM_CH*CODE_W-1:0] ch_code,
   input logic [NUM_CH-1:0]        ch_en,
   input logic [NUM_CH-1:0]        ch_fast
);

   logic [CODE_W-1:0] code_arr [NUM_CH];
   logic [ADDR_W-1:0] last_addr;
   logic [CODE_W-1:0] last_code;

   always_comb begin
      for (int k = 0; k < NUM_CH; k++) begin
         code_arr[k] = ch_code[k*CODE_W +: CODE_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_addr <= '0;
         last_code <= '0;
      end else begin
         last_addr <= wr_addr;
         last_code <= wr_code;
      end
   end

   // R1: reset clears the live state
   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |-> (ch_code == '0 && ch_fast == '0 && work_pdn == '0));

   // R4: no live change while load is inactive
   a_r4_hold_when_unloaded: assert property (@(posedge clk) disable iff (!rst_n)
      !load_act |=> ($stable(ch_code) && $stable(ch_fast) && $stable(work_pdn)));

   // R3: pass-through of a write while load is active
   a_r3_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && load_act && (int'(wr_addr) < NUM_CH))
      |=> (code_arr[last_addr] == last_code));

   // R5: global power-down forces every enable low
   a_r5_global_off: assert property (@(posedge clk) disable iff (!rst_n)
      gpd_act |-> (ch_en == '0));

   // R7: enable follows the channel bit when not globally off
   a_r7_enable_follows_bit: assert property (@(posedge clk) disable iff (!rst_n)
      !gpd_act |-> (ch_en == ~work_pdn));

endmodule

bind chan_latch_bank clb_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_valid (wr_valid),
   .wr_addr  (wr_addr),
   .wr_code  (wr_code),
   .load_act (load_act),
   .gpd_act  (gpd_act),
   .work_pdn (work_pdn),
   .ch_code  (ch_code),
   .ch_en    (ch_en),
   .ch_fast  (ch_fast)
);

// File: tb/chan_latch_bank_tb.sv
module chan_latch_bank_tb;

   localparam int NCH = 4;
   localparam int CW  = 10;
   localparam int SYN = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_valid = 1'b0;
   logic [1:0]    wr_addr = '0;
   logic [CW-1:0] wr_code = '0;
   logic          wr_pdn = 1'b0;
   logic          wr_fast = 1'b0;
   logic          load_n = 1'b1;
   logic          gpd_n = 1'b1;
   logic [NCH*CW-1:0] ch_code;
   logic [NCH-1:0]    ch_en;
   logic [NCH-1:0]    ch_fast;

   int    n_chk = 0;
   int    n_bad = 0;
   bit    cmp_on = 1'b0;
   bit    done = 1'b0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   chan_latch_bank u_dut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_code(wr_code), .wr_pdn(wr_pdn), .wr_fast(wr_fast),
      .load_n(load_n), .gpd_n(gpd_n),
      .ch_code(ch_code), .ch_en(ch_en), .ch_fast(ch_fast)
   );

   // behavioural reference model
   int m_hc[NCH], m_hp[NCH], m_hf[NCH];
   int m_lc[NCH], m_lp[NCH], m_lf[NCH];
   int ld_q[$];
   int gd_q[$];
   int gd_eff = 1;

   task automatic model_clear();
      for (int k = 0; k < NCH; k++) begin
         m_hc[k] = 0; m_hp[k] = 0; m_hf[k] = 0;
         m_lc[k] = 0; m_lp[k] = 0; m_lf[k] = 0;
      end
      ld_q.delete(); gd_q.delete();
      for (int i = 0; i < SYN; i++) begin
         ld_q.push_back(1); gd_q.push_back(1);
      end
      gd_eff = 1;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         model_clear();
      end else begin
         int ld_eff;
         ld_eff = ld_q[SYN-1];
         for (int k = 0; k < NCH; k++) begin
            bit hit;
            hit = wr_valid && (int'(wr_addr) == k);
            if (ld_eff == 0) begin
               if (hit) begin
                  m_lc[k] = int'(wr_code); m_lp[k] = int'(wr_pdn); m_lf[k] = int'(wr_fast);
               end else begin
                  m_lc[k] = m_hc[k]; m_lp[k] = m_hp[k]; m_lf[k] = m_hf[k];
               end
            end
            if (hit) begin
               m_hc[k] = int'(wr_code); m_hp[k] = int'(wr_pdn); m_hf[k] = int'(wr_fast);
            end
         end
         ld_q.push_front(int'(load_n)); void'(ld_q.pop_back());
         gd_q.push_front(int'(gpd_n));  void'(gd_q.pop_back());
         gd_eff = gd_q[SYN-1];
      end
   end

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on) begin
         logic [NCH*CW-1:0] ec;
         logic [NCH-1:0]    ee, ef;
         for (int k = 0; k < NCH; k++) begin
            ec[k*CW +: CW] = CW'(m_lc[k]);
            ef[k] = m_lf[k][0];
            ee[k] = (gd_eff != 0) && (m_lp[k] == 0);
         end
         check({cur_req, " code"},   64'(ch_code), 64'(ec));
         check({cur_req, " enable"}, 64'(ch_en),   64'(ee));
         check({cur_req, " speed"},  64'(ch_fast), 64'(ef));
      end
   end

   task automatic tick(int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic put(int a, int c, bit p, bit f);
      wr_valid = 1'b1; wr_addr = 2'(a); wr_code = CW'(c); wr_pdn = p; wr_fast = f;
      tick();
      wr_valid = 1'b0;
   endtask

   function automatic logic [CW-1:0] slice(int k);
      return ch_code[k*CW +: CW];
   endfunction

   initial begin
      #200000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      model_clear();
      tick(3);
      rst_n = 1'b1;
      tick();
      cmp_on = 1'b1;
      // R1: cleared state
      check("R1 code", 64'(ch_code), 64'd0);
      check("R1 enable", 64'(ch_en), 64'hF);
      check("R1 speed", 64'(ch_fast), 64'd0);

      // R3 / R7 / R8: load held low, pass-through
      cur_req = "R3";
      load_n = 1'b0;
      tick(SYN + 1);
      put(2, 'h155, 1'b0, 1'b1);
      check("R3 pass-through ch2", 64'(slice(2)), 64'h155);
      check("R7 fast bit ch2", 64'(ch_fast[2]), 64'd1);
      put(0, 'h001, 1'b1, 1'b0);
      put(1, 'h200, 1'b0, 1'b0);
      put(3, 'h3FF, 1'b0, 1'b1);
      check("R7 ch0 powered down", 64'(ch_en), 64'b1110);
      check("R3 ch3 full code", 64'(slice(3)), 64'h3FF);
      cur_req = "R8";
      tick(4);

      // R2 / R4: load high stages writes only
      cur_req = "R4";
      load_n = 1'b1;
      tick(SYN + 1);
      put(1, 'h3AA, 1'b1, 1'b1);
      put(3, 'h0F0, 1'b0, 1'b0);
      put(0, 'h0AB, 1'b0, 1'b0);
      tick(3);
      check("R4 ch1 unchanged", 64'(slice(1)), 64'h200);
      check("R2 ch2 untouched", 64'(slice(2)), 64'h155);

      // R9: writes to ch0 running through the transfer edge
      cur_req = "R9";
      load_n = 1'b0;
      put(0, 'h011, 1'b0, 1'b1);
      put(0, 'h022, 1'b0, 1'b1);
      put(0, 'h033, 1'b0, 1'b1);
      check("R9 write wins ch0", 64'(slice(0)), 64'h033);
      check("R4 ch1 transferred", 64'(slice(1)), 64'h3AA);
      check("R4 ch3 transferred", 64'(slice(3)), 64'h0F0);
      tick(2);

      // R5 / R6: global power-down
      cur_req = "R5";
      gpd_n = 1'b0;
      tick(SYN + 1);
      check("R5 all disabled", 64'(ch_en), 64'd0);
      put(2, 'h100, 1'b0, 1'b0);
      tick(2);
      cur_req = "R6";
      gpd_n = 1'b1;
      tick(SYN + 1);
      check("R6 ch1 code kept", 64'(slice(1)), 64'h3AA);
      check("R6 enables restored", 64'(ch_en), 64'b1101);
      check("R6 ch2 new code", 64'(slice(2)), 64'h100);

      // R2: write to out-of-range address in a 4-channel bank cannot occur (2-bit);
      // R8: random mixture
      cur_req = "R8";
      for (int i = 0; i < 600; i++) begin
         wr_valid = ($urandom_range(0, 2) != 0);
         wr_addr  = 2'($urandom_range(0, 3));
         wr_code  = CW'($urandom);
         wr_pdn   = 1'($urandom);
         wr_fast  = 1'($urandom);
         if ($urandom_range(0, 9) == 0) load_n = ~load_n;
         if ($urandom_range(0, 19) == 0) gpd_n = ~gpd_n;
         tick();
      end
      wr_valid = 1'b0;
      tick(4);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule